// File: doc/BRIEF.md
# Typematic Key Repeat Timer

This block produces auto-repeat strobes for a key that stays pressed. Software loads one configuration byte. Bits 6:5 of that byte hold a 2-bit delay field D. Bits 4:3 hold a 2-bit exponent B. Bits 2:0 hold a 3-bit mantissa A. Bit 7 carries no meaning and is discarded.

While `key_held` is high, the block waits an initial delay of (1+D) delay units. It then emits one repeat strobe, and after that one more strobe every (8+A)·2^B base ticks, for as long as the key stays held.

A prescaler divides the clock into base ticks of `TICK_US` microseconds. The default is 4.17 ms per tick, and one delay unit is about 250 ms. The period is computed by shifting the mantissa sum left, so no multiplier is needed for it. Both the write and the key level are plain control pins. No handshake applies: a write is taken in the cycle its strobe is high, and nothing can apply back-pressure to the repeat strobe.

Top module: `typematic_timer`

## Requirements
- R1: After reset the configuration is D=1, B=1, A=3 (byte 0x2B). This gives a delay of 2 units and a period of 22 ticks.
- R2: Bit 7 of `wr_data` is ignored. Writing a value with bit 7 set produces exactly the same timing as the same value with bit 7 clear.
- R3: The first strobe follows the start of a hold after exactly (1+D)·DELAY_UNIT ticks. D is `wr_data[6:5]`.
- R4: Each later strobe follows the previous one after (8+A)<<B ticks. A is `wr_data[2:0]` and B is `wr_data[4:3]`.
- R5: One tick lasts TICK_DIV = (CLK_HZ/10^6)·TICK_US clock cycles. The tick time base restarts whenever a hold starts or restarts.
- R6: When `key_held` goes low, both counters clear. No strobe appears while the key is released, and a pending repeat is dropped.
- R7: A write while the key is held clears the counters. Timing then restarts from the cycle after the write under the new configuration, and no strobe appears in the cycle after a write.
- R8: `repeat_o` is high for exactly one clock cycle per repeat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_data | input | 8 | Configuration byte: delay, exponent and mantissa fields |
| key_held | input | 1 | High while the key is pressed |
| repeat_o | output | 1 | One-cycle repeat strobe |

## Verification
Every strobe's arrival cycle is compared with a value computed from the formula, across the smallest and largest codes and the reset default. A mistake in the delay multiply or the exponent shift shifts these stamps. A set bit 7 leaking into the delay field lengthens the delay. Releasing the key just before the first strobe is due catches a design that lets a pending repeat escape. A mid-hold write catches a design that keeps counting on the old settings. A strobe held high for two cycles shows up as an unexpected extra strobe.

// File: rtl/typ_pkg.sv
package typ_pkg;
  typedef struct packed {
    logic [1:0] dly;
    logic [1:0] expo;
    logic [2:0] mant;
  } rate_cfg_t;

  localparam rate_cfg_t RATE_DEFAULT = '{dly: 2'd1, expo: 2'd1, mant: 3'd3};
  localparam int MAX_PERIOD_TICKS = 15 * 8;
endpackage

// File: rtl/typ_prescaler.sv
module typ_prescaler #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  logic [W-1:0] cnt;

  assign tick = run && (cnt == W'(DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (!run)  cnt <= '0;
    else if (tick)  cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/typ_rate_decode.sv
module typ_rate_decode
  import typ_pkg::*;
#(
  parameter int DELAY_UNIT = 60,
  parameter int CNT_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [6:0]       wr_bits,
  output logic [CNT_W-1:0] delay_ticks,
  output logic [CNT_W-1:0] period_ticks
);
  rate_cfg_t cfg;

  always_ff @(posedge clk) begin
    if (!rst_n)     cfg <= RATE_DEFAULT;
    else if (wr_en) cfg <= rate_cfg_t'(wr_bits);
  end

  always_comb begin
    delay_ticks  = CNT_W'((32'(cfg.dly) + 32'd1) * DELAY_UNIT);
    period_ticks = CNT_W'((32'd8 + 32'(cfg.mant)) << cfg.expo);
  end
endmodule

// File: rtl/typ_repeat_ctr.sv
module typ_repeat_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             tick,
  input  logic [CNT_W-1:0] delay_ticks,
  input  logic [CNT_W-1:0] period_ticks,
  output logic             fire
);
  logic             in_repeat;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] target;

  assign target = in_repeat ? period_ticks : delay_ticks;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      in_repeat <= 1'b0;
      fire      <= 1'b0;
    end else begin
      fire <= 1'b0;
      if (clear) begin
        cnt       <= '0;
        in_repeat <= 1'b0;
      end else if (tick) begin
        if (cnt == target - 1'b1) begin
          fire      <= 1'b1;
          cnt       <= '0;
          in_repeat <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/typematic_timer.sv
module typematic_timer
  import typ_pkg::*;
#(
  parameter int CLK_HZ     = 50_000_000,
  parameter int TICK_US    = 4170,
  parameter int DELAY_UNIT = 60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       key_held,
  output logic       repeat_o
);
  localparam int TICK_RAW  = (CLK_HZ / 1_000_000) * TICK_US;
  localparam int TICK_DIV  = (TICK_RAW > 0) ? TICK_RAW : 1;
  localparam int MAX_TICKS = (4 * DELAY_UNIT > MAX_PERIOD_TICKS) ? 4 * DELAY_UNIT : MAX_PERIOD_TICKS;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);

  logic             run;
  logic             tick;
  logic [CNT_W-1:0] delay_ticks;
  logic [CNT_W-1:0] period_ticks;

  assign run = key_held && !wr_en;

  typ_prescaler #(.DIV(TICK_DIV)) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .tick (tick)
  );

  typ_rate_decode #(.DELAY_UNIT(DELAY_UNIT), .CNT_W(CNT_W)) u_dec (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_bits     (wr_data[6:0]),
    .delay_ticks (delay_ticks),
    .period_ticks(period_ticks)
  );

  typ_repeat_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (!run),
    .tick        (tick),
    .delay_ticks (delay_ticks),
    .period_ticks(period_ticks),
    .fire        (repeat_o)
  );
endmodule

// File: rtl/typ_chk.sv
module typ_chk #(
  parameter int MIN_CYC = 12
) (
  input logic clk,
  input logic rst_n,
  input logic wr_en,
  input logic key_held,
  input logic tick,
  input logic repeat_o
);
  int unsigned held_cyc;

  always_ff @(posedge clk) begin
    if (!rst_n || !key_held || wr_en) held_cyc <= 0;
    else if (held_cyc < MIN_CYC)      held_cyc <= held_cyc + 1;
  end

  AST_ONE_CYCLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    repeat_o |=> !repeat_o); // R8
  AST_QUIET_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !key_held |=> !repeat_o); // R6
  AST_QUIET_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !repeat_o); // R7
  AST_MIN_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    repeat_o |-> held_cyc >= MIN_CYC); // R3
  AST_PULSE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    repeat_o |-> $past(tick)); // R5
endmodule

bind typematic_timer typ_chk #(.MIN_CYC(TICK_DIV * DELAY_UNIT)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .key_held(key_held),
  .tick    (tick),
  .repeat_o(repeat_o)
);

// File: tb/tb_typematic_timer.sv
module tb_typematic_timer;
  localparam int DIV  = 4;
  localparam int UNIT = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       key_held = 1'b0;
  logic       repeat_o;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  int exp_t[$];
  string exp_tag[$];

  typematic_timer #(.CLK_HZ(1_000_000), .TICK_US(DIV), .DELAY_UNIT(UNIT)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .key_held(key_held), .repeat_o(repeat_o)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compares each observed strobe with the next queued stamp
  always @(negedge clk) begin
    if (rst_n && repeat_o) begin
      checks++;
      if (exp_t.size() == 0) begin
        fails++;
        $display("FAIL R8/R6: unexpected strobe at cycle %0d, expected none", cyc);
      end else begin
        int t;
        string tg;
        t  = exp_t.pop_front();
        tg = exp_tag.pop_front();
        if (t != cyc) begin
          fails++;
          $display("FAIL %s: strobe at cycle %0d, expected %0d", tg, cyc, t);
        end
      end
    end
  end

  task automatic write_cfg(input logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic push_expect(input int t0, input int d, input int a, input int b,
                             input int n, input string tg);
    for (int k = 0; k < n; k++) begin
      exp_t.push_back(t0 + ((1 + d) * UNIT + k * ((8 + a) << b)) * DIV);
      exp_tag.push_back(tg);
    end
  endtask

  task automatic check_drained(input string tg);
    checks++;
    if (exp_t.size() != 0) begin
      fails++;
      $display("FAIL %s: %0d strobes missing, expected 0 pending", tg, exp_t.size());
      exp_t.delete(); exp_tag.delete();
    end
  endtask

  // hold the key for n strobes, release just after the last, then stay quiet
  task automatic hold_case(input int d, input int a, input int b, input int n, input string tg);
    int t0;
    int last;
    @(negedge clk);
    key_held = 1'b1; t0 = cyc;
    push_expect(t0, d, a, b, n, tg);
    last = t0 + ((1 + d) * UNIT + (n - 1) * ((8 + a) << b)) * DIV;
    while (cyc < last + 2) @(negedge clk);
    key_held = 1'b0;
    repeat (600) @(negedge clk);
    check_drained(tg);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (repeat_o !== 1'b0) begin
      fails++;
      $display("FAIL R1: repeat_o after reset %b, expected 0", repeat_o);
    end

    // R1: defaults D=1 B=1 A=3
    hold_case(1, 3, 1, 3, "R1");
    // R3/R4: smallest code 0x00
    write_cfg(8'h00);
    hold_case(0, 0, 0, 4, "R4");
    // R3/R4: largest code 0x7F
    write_cfg(8'h7F);
    hold_case(3, 7, 3, 2, "R3");
    // R2: bit 7 set, 0xE5 acts as 0x65 (D=3 B=0 A=5)
    write_cfg(8'hE5);
    hold_case(3, 5, 0, 3, "R2");
    // R4/R5: 0x52 -> D=2 B=2 A=2
    write_cfg(8'h52);
    hold_case(2, 2, 2, 2, "R5");

    // R6: release one cycle before the first strobe is due (0x00: due at t0+12)
    write_cfg(8'h00);
    begin
      int t0;
      @(negedge clk);
      key_held = 1'b1; t0 = cyc;
      while (cyc < t0 + 11) @(negedge clk);
      key_held = 1'b0;
      repeat (200) @(negedge clk);
      check_drained("R6");
      checks++;
      if (repeat_o !== 1'b0) begin
        fails++;
        $display("FAIL R6: repeat_o %b while released, expected 0", repeat_o);
      end
    end

    // R7: write 0x20 (D=1 B=0 A=0) between first and second strobe
    begin
      int t0;
      int c;
      @(negedge clk);
      key_held = 1'b1; t0 = cyc;
      push_expect(t0, 0, 0, 0, 1, "R7");
      while (cyc < t0 + 30) @(negedge clk);
      c = cyc;
      wr_en = 1'b1; wr_data = 8'h20;
      push_expect(c + 1, 1, 0, 0, 3, "R7");
      @(negedge clk);
      wr_en = 1'b0;
      while (cyc < c + 1 + (6 + 2 * 8) * DIV + 2) @(negedge clk);
      key_held = 1'b0;
      repeat (200) @(negedge clk);
      check_drained("R7");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule